// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Event-Code Output

This block collects interrupt requests from a set of on-chip peripherals, a non-maskable request and an external prioritised request, and decides which one the CPU should take. Each on-chip source has a 5-bit priority register written through a simple write port. Arbitration among on-chip sources uses all five bits. The level handed to the CPU keeps only the upper four bits. Two sources that report the same 4-bit level are therefore still ordered by the hidden low bit, and only then by source index.

The arbiter registers three results. The first is an interrupt-pending flag, set when the winning level is above the CPU mask or when the non-maskable request is active. The second is the winner's 4-bit level. The third is an event-code register that the CPU loads with an acknowledge strobe. Every source has its own event code, so a single common handler can branch on that value as an offset. The event register changes only on acknowledge and holds its value while the handler reads it.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, every priority register holds 0x00, and `irq_pend`, `irq_lvl` and `evt_code` are all 0.
- R2: One cycle after the inputs are applied, `irq_lvl` equals the winning on-chip source's 5-bit priority shifted right by one (priority bits [4:1]). For example, 0x1A and 0x1B both give 0xD.
- R3: On-chip sources are compared on the full 5-bit priority. With sources at 0x1A and 0x1B both requesting, the 0x1B source wins.
- R4: When requesting on-chip sources have identical 5-bit priorities, the lowest source index wins.
- R5: A source whose priority register holds 0x00 or 0x01 is disabled. It never wins, and on its own it gives `irq_lvl`=0 and `irq_pend`=0. Writes of these values are stored like any other value.
- R6: On a cycle with `ack`=1, `evt_code` loads the code of that cycle's winner, where on-chip source i has code CODE_BASE + i*CODE_STEP (0x400 + i*0x20 by default). With `ack`=0, `evt_code` keeps its value whatever the requests do.
- R7: `nmi`=1 wins over every other request and sets `irq_pend`=1 whatever the mask is. It reports `irq_lvl`=0xF and event code NMI_CODE (0x1C0).
- R8: A non-zero `ext_lvl` wins over the on-chip winner when it is equal to or above that winner's 4-bit level, or when no on-chip source is eligible. It then reports `irq_lvl`=`ext_lvl` and code EXT_CODE_BASE + `ext_lvl`*CODE_STEP (0x200 + L*0x20). If it is below the on-chip level, the on-chip source wins.
- R9: Without `nmi`, `irq_pend` is 1 exactly when the winning 4-bit level is strictly greater than `cpu_mask`.
- R10: An `ack` in a cycle with no eligible request leaves `evt_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Priority register write strobe |
| wr_idx | input | IDX_W (3) | Source index to write |
| wr_data | input | 5 | Priority value to store |
| req | input | NUM_SRC (8) | On-chip request lines, one per source |
| ext_lvl | input | 4 | External request level, 0 means no request |
| nmi | input | 1 | Non-maskable request |
| cpu_mask | input | 4 | CPU current mask level |
| ack | input | 1 | CPU acknowledge, loads the event register |
| irq_pend | output | 1 | Interrupt pending towards the CPU |
| irq_lvl | output | 4 | Winning level, 4-bit |
| evt_code | output | CODE_W (12) | Latched event code of the acknowledged winner |

## Verification
A priority write takes effect at the edge where it is applied, so the bench always spends a separate cycle on the write before it drives requests. `irq_pend` and `irq_lvl` are registered one stage behind `req`, `ext_lvl`, `nmi` and `cpu_mask`, and `evt_code` loads at that same edge whenever `ack` is high. The bench therefore drives each stimulus on a falling edge and checks all three outputs at the next falling edge. Its reference function takes the maximum 5-bit priority, breaks ties by the lowest index, then applies the external and non-maskable overrides. When nothing is eligible, it carries the previous expected code forward.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 5;
  localparam int LVL_W  = 4;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_CHIP = 2'd1,
    WIN_EXT  = 2'd2,
    WIN_NMI  = 2'd3
  } win_kind_e;

  // A 5-bit priority is reported to the CPU with its lowest bit dropped.
  function automatic logic [LVL_W-1:0] prio_to_lvl(input logic [PRIO_W-1:0] p);
    return p[PRIO_W-1:1];
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [PRIO_W-1:0]         wr_data,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [PRIO_W-1:0] prio_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        prio_q <= wr_data;
      end
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/irq_chip_arb.sv
module irq_chip_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      chip_valid,
  output logic [PRIO_W-1:0]         chip_prio,
  output logic [IDX_W-1:0]          chip_idx
);
  logic [NUM_SRC-1:0] eligible;

  // Priorities 0x00 and 0x01 reduce to level 0 and never compete.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign eligible[g] = req[g] &&
                         (prio_to_lvl(prio_flat[g*PRIO_W +: PRIO_W]) != '0);
  end

  // Scan upward with a strict compare, so the lowest index keeps an equal tie.
  always_comb begin
    chip_valid = 1'b0;
    chip_prio  = '0;
    chip_idx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] &&
          (!chip_valid || (prio_flat[i*PRIO_W +: PRIO_W] > chip_prio))) begin
        chip_valid = 1'b1;
        chip_prio  = prio_flat[i*PRIO_W +: PRIO_W];
        chip_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_final_sel.sv
module irq_final_sel
  import irq_arb_pkg::*;
#(
  parameter int                 IDX_W         = 3,
  parameter int                 CODE_W        = 12,
  parameter logic [CODE_W-1:0]  CODE_BASE     = 12'h400,
  parameter logic [CODE_W-1:0]  CODE_STEP     = 12'h020,
  parameter logic [CODE_W-1:0]  EXT_CODE_BASE = 12'h200,
  parameter logic [CODE_W-1:0]  NMI_CODE      = 12'h1C0
) (
  input  logic                 chip_valid,
  input  logic [PRIO_W-1:0]    chip_prio,
  input  logic [IDX_W-1:0]     chip_idx,
  input  logic [LVL_W-1:0]     ext_lvl,
  input  logic                 nmi,
  input  logic [LVL_W-1:0]     cpu_mask,
  output win_kind_e            win_kind,
  output logic [LVL_W-1:0]     win_lvl,
  output logic [CODE_W-1:0]    win_code,
  output logic                 pend_next
);
  logic [LVL_W-1:0] chip_lvl;
  logic             ext_take;

  assign chip_lvl = prio_to_lvl(chip_prio);
  assign ext_take = (ext_lvl != '0) && (!chip_valid || (ext_lvl >= chip_lvl));

  always_comb begin
    if (nmi) begin
      win_kind = WIN_NMI;
      win_lvl  = '1;
      win_code = NMI_CODE;
    end else if (ext_take) begin
      win_kind = WIN_EXT;
      win_lvl  = ext_lvl;
      win_code = EXT_CODE_BASE + CODE_W'(ext_lvl) * CODE_STEP;
    end else if (chip_valid) begin
      win_kind = WIN_CHIP;
      win_lvl  = chip_lvl;
      win_code = CODE_BASE + CODE_W'(chip_idx) * CODE_STEP;
    end else begin
      win_kind = WIN_NONE;
      win_lvl  = '0;
      win_code = '0;
    end
  end

  assign pend_next = nmi || (win_lvl > cpu_mask);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int                 NUM_SRC       = 8,
  parameter int                 IDX_W         = $clog2(NUM_SRC),
  parameter int                 CODE_W        = 12,
  parameter logic [CODE_W-1:0]  CODE_BASE     = 12'h400,
  parameter logic [CODE_W-1:0]  CODE_STEP     = 12'h020,
  parameter logic [CODE_W-1:0]  EXT_CODE_BASE = 12'h200,
  parameter logic [CODE_W-1:0]  NMI_CODE      = 12'h1C0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [4:0]         wr_data,
  input  logic [NUM_SRC-1:0] req,
  input  logic [3:0]         ext_lvl,
  input  logic               nmi,
  input  logic [3:0]         cpu_mask,
  input  logic               ack,
  output logic               irq_pend,
  output logic [3:0]         irq_lvl,
  output logic [CODE_W-1:0]  evt_code
);
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      chip_valid;
  logic [PRIO_W-1:0]         chip_prio;
  logic [IDX_W-1:0]          chip_idx;
  win_kind_e                 win_kind;
  logic [LVL_W-1:0]          win_lvl;
  logic [CODE_W-1:0]         win_code;
  logic                      pend_next;

  irq_prio_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .prio_flat(prio_flat)
  );

  irq_chip_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chip (
    .req(req), .prio_flat(prio_flat), .chip_valid(chip_valid),
    .chip_prio(chip_prio), .chip_idx(chip_idx)
  );

  irq_final_sel #(
    .IDX_W(IDX_W), .CODE_W(CODE_W), .CODE_BASE(CODE_BASE),
    .CODE_STEP(CODE_STEP), .EXT_CODE_BASE(EXT_CODE_BASE), .NMI_CODE(NMI_CODE)
  ) u_sel (
    .chip_valid(chip_valid), .chip_prio(chip_prio), .chip_idx(chip_idx),
    .ext_lvl(ext_lvl), .nmi(nmi), .cpu_mask(cpu_mask),
    .win_kind(win_kind), .win_lvl(win_lvl), .win_code(win_code),
    .pend_next(pend_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= 1'b0;
      irq_lvl  <= '0;
      evt_code <= '0;
    end else begin
      irq_pend <= pend_next;
      irq_lvl  <= win_lvl;
      if (ack && (win_kind != WIN_NONE)) begin
        evt_code <= win_code;
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              nmi,
  input logic [3:0]        ext_lvl,
  input logic [3:0]        cpu_mask,
  input logic              ack,
  input logic              irq_pend,
  input logic [3:0]        irq_lvl,
  input logic [CODE_W-1:0] evt_code
);
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
    ($past(nmi) && !$past(rst)) |-> (irq_pend && (irq_lvl == 4'hF))); // R7

  AST_PEND_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && !$past(nmi) && !$past(rst)) |-> (irq_lvl > $past(cpu_mask))); // R9

  AST_NOPEND_AT_MASK: assert property (@(posedge clk) disable iff (rst)
    (!$past(nmi) && !$past(rst) && (irq_lvl > $past(cpu_mask))) |-> irq_pend); // R9

  AST_EXT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (!$past(nmi) && !$past(rst) && ($past(ext_lvl) != 4'h0))
      |-> (irq_lvl >= $past(ext_lvl))); // R8

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(ack) && !$past(rst)) |-> $stable(evt_code)); // R6

  AST_LVL_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (irq_lvl == 4'h0) |-> !irq_pend); // R5
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .nmi(nmi), .ext_lvl(ext_lvl), .cpu_mask(cpu_mask),
  .ack(ack), .irq_pend(irq_pend), .irq_lvl(irq_lvl), .evt_code(evt_code)
);

// File: tb/irq_prio_arb_tb_top.sv
module irq_prio_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 8;
  localparam int IW         = 3;
  localparam int WATCHDOG   = 20000;

  logic            clk = 1'b0;
  logic            rst;
  logic            wr_en;
  logic [IW-1:0]   wr_idx;
  logic [4:0]      wr_data;
  logic [NSRC-1:0] req;
  logic [3:0]      ext_lvl;
  logic            nmi;
  logic [3:0]      cpu_mask;
  logic            ack;
  logic            irq_pend;
  logic [3:0]      irq_lvl;
  logic [11:0]     evt_code;

  int checks = 0;
  int fails  = 0;
  logic [4:0]  mprio [NSRC];
  logic [11:0] exp_code = 12'h000;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arb dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req(req), .ext_lvl(ext_lvl), .nmi(nmi), .cpu_mask(cpu_mask), .ack(ack),
    .irq_pend(irq_pend), .irq_lvl(irq_lvl), .evt_code(evt_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [4:0] val);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = val;
    req = '0; ext_lvl = '0; nmi = 1'b0; ack = 1'b0;
    tick();
    wr_en = 1'b0;
    mprio[idx] = val;
  endtask

  // Reference: max 5-bit priority, lowest index on ties, then external, then NMI.
  task automatic model(input logic [NSRC-1:0] rq, input logic [3:0] ex, input logic nm,
                       output logic valid, output logic [3:0] lvl, output logic [11:0] code);
    int best = -1;
    logic [3:0] clvl;
    for (int i = 0; i < NSRC; i++) begin
      if (rq[i] && mprio[i] >= 5'd2 && (best < 0 || mprio[i] > mprio[best])) best = i;
    end
    clvl = (best >= 0) ? mprio[best][4:1] : 4'h0;
    if (nm) begin
      valid = 1'b1; lvl = 4'hF; code = 12'h1C0;
    end else if (ex != 4'h0 && (best < 0 || ex >= clvl)) begin
      valid = 1'b1; lvl = ex; code = 12'h200 + 12'(ex) * 12'h020;
    end else if (best >= 0) begin
      valid = 1'b1; lvl = clvl; code = 12'h400 + 12'(best) * 12'h020;
    end else begin
      valid = 1'b0; lvl = 4'h0; code = 12'h000;
    end
  endtask

  // Drive one request pattern with ack, then check all three outputs.
  task automatic arb(input string tag, input logic [NSRC-1:0] rq, input logic [3:0] ex,
                     input logic nm, input logic [3:0] msk);
    logic v; logic [3:0] l; logic [11:0] c;
    req = rq; ext_lvl = ex; nmi = nm; cpu_mask = msk; ack = 1'b1;
    model(rq, ex, nm, v, l, c);
    if (v) exp_code = c;
    tick();
    ack = 1'b0;
    chk({tag, " lvl"}, 32'(irq_lvl), 32'(l));
    chk({tag, " pend"}, 32'(irq_pend), 32'(nm || (l > msk)));
    chk({tag, " code"}, 32'(evt_code), 32'(exp_code));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NSRC; i++) mprio[i] = 5'h00;
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; req = '0;
    ext_lvl = '0; nmi = 1'b0; cpu_mask = '0; ack = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pend", 32'(irq_pend), 0);
    chk("R1 reset lvl", 32'(irq_lvl), 0);
    chk("R1 reset code", 32'(evt_code), 0);
    arb("R1 R5 reset prio zero disables", 8'hFF, 4'h0, 1'b0, 4'h0);

    wr(2, 5'h1A); wr(5, 5'h1B);
    arb("R2 R3 0x1B beats 0x1A", 8'b0010_0100, 4'h0, 1'b0, 4'h0);
    chk("R2 level 0xD", 32'(irq_lvl), 32'hD);
    chk("R3 code src5", 32'(evt_code), 32'h4A0);
    arb("R2 single 0x1A", 8'b0000_0100, 4'h0, 1'b0, 4'h0);

    wr(3, 5'h1B);
    arb("R4 tie lowest index", 8'b0010_1100, 4'h0, 1'b0, 4'h0);
    chk("R4 code src3", 32'(evt_code), 32'h460);

    wr(1, 5'h01);
    arb("R5 R10 prio 0x01 silent", 8'b0000_0010, 4'h0, 1'b0, 4'h0);
    chk("R10 code unchanged", 32'(evt_code), 32'h460);

    arb("R7 nmi over all", 8'b0010_1100, 4'hF, 1'b1, 4'hF);
    chk("R7 nmi code", 32'(evt_code), 32'h1C0);

    arb("R8 ext equal level wins", 8'b0000_0100, 4'hD, 1'b0, 4'h0);
    chk("R8 ext code", 32'(evt_code), 32'h3A0);
    arb("R8 ext lower loses", 8'b0000_0100, 4'hC, 1'b0, 4'h0);
    arb("R8 ext alone", 8'b0000_0000, 4'h3, 1'b0, 4'h0);

    arb("R9 level equal mask", 8'b0000_0100, 4'h0, 1'b0, 4'hD);
    chk("R9 no pend at mask", 32'(irq_pend), 0);
    arb("R9 level above mask", 8'b0000_0100, 4'h0, 1'b0, 4'hC);

    // R6: without ack the event register holds while requests change
    req = 8'b0010_0000; ext_lvl = 4'h0; nmi = 1'b1; ack = 1'b0;
    tick();
    chk("R6 hold without ack", 32'(evt_code), 32'(exp_code));
    nmi = 1'b0;

    for (int n = 0; n < 400; n++) begin
      wr(int'($urandom_range(0, NSRC-1)), 5'($urandom_range(0, 31)));
      arb("R2 R3 R4 R6 R8 R9 random",
          NSRC'($urandom),
          ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0,
          ($urandom_range(0, 15) == 0),
          4'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule